// File: doc/BRIEF.md
# Vector Element Index Remapper

This block sits beside the loop sequencer of a vector unit. The sequencer walks a linear element counter from 0 up to the vector length minus one. For every step, the block turns that counter into a reordered element index for each of five operand slots: three sources (A, B, C) and two destinations (the primary result and a second write target). Without remapping, elements are taken in plain order 0, 1, 2, and so on. With remapping, an operand can walk a 2D or 3D array in a transposed or permuted order, such as a matrix column by column. Each sub-element of a short sub-vector is presented as its own step.

Four shape generators are shared by the five slots. Each generator holds a shape word and a set of nested x/y/z counters. These counters advance once per valid step, whichever slots read them. A control word gives each slot a 2-bit choice of generator and an enable bit. Several slots may pick the same generator. A slot whose enable is clear passes the raw loop counter through. Presenting loop counter 0 restarts every generator. Results are registered and appear one cycle after the step, together with a valid flag and a per-slot active flag.

Top module: `vec_remap`

## Requirements
- R1: After reset, `outValid`, every slot index and every `remapActive` bit are 0.
- R2: `outValid` is high in the cycle after a cycle with `stepValid` high, and low otherwise. Indices and active flags for a step appear in that same cycle.
- R3: A slot whose enable bit is clear outputs the loop counter of the step, and its active flag is 0.
- R4: The shape word holds x, y and z sizes minus one in bits 5:0, 11:6 and 17:12, and a permutation code in bits 20:18. The index is x + y·X + z·X·Y, where X and Y are the x and y sizes. Code 0 varies x fastest, then y, then z. A 3×2 shape therefore yields 0..5.
- R5: Code 1 varies y fastest, then x, then z. A 3×3 shape yields 0,3,6,1,4,7,2,5,8.
- R6: Code 5 varies z fastest, then y, then x. Codes 2, 3 and 4 give inner/middle/outer orders x/z/y, y/z/x and z/x/y. A 2×2×2 shape under code 5 yields 0,4,2,6,1,5,3,7.
- R7: After the last position of a shape, the next step yields index 0 and the walk repeats.
- R8: A step with loop counter 0 restarts every generator. Every slot outputs 0 for that step, and the following step continues from the second position of the walk.
- R9: Control bits 1:0, 3:2, 5:4, 7:6 and 9:8 select the generator for slots A, B, C, primary destination and second destination. Bits 14:10 are the enables for the same slots in the same order. Slots that select the same generator output equal indices.
- R10: Without a step, outputs hold their values and generator counters do not advance.
- R11: Permutation codes 6 and 7 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| shapeWe | input | 1 | Write strobe for a shape word |
| shapeSel | input | 2 | Generator written by `shapeWe` |
| shapeData | input | 21 | Shape word (sizes and permutation code) |
| ctrlWe | input | 1 | Write strobe for the control word |
| ctrlData | input | 15 | Control word (slot selectors and enables) |
| stepValid | input | 1 | A loop step is presented this cycle |
| loopIdx | input | 20 | Linear loop counter of the step |
| outValid | output | 1 | Slot indices belong to the step of the previous cycle |
| remapIdx | output | 100 | Five 20-bit indices; slot k in bits 20k+19:20k |
| remapActive | output | 5 | Per-slot flag: remapping was applied |

## Verification
The hardest case to reach is shared generator state, seen through several slots at once. One generator must drive two slots, while other slots use different shapes and permutations in the same step. A restart must then land in the middle of a walk, and idle cycles must sit between steps. The stimulus loads all four generators with different shapes and maps the slots so that two of them share one generator. It then steps part way into the walk, inserts idle cycles, and issues a loop counter of 0 mid-walk. It checks that every slot follows its own walk and that the idle cycles did not advance any counter.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int DIM_W      = 6;
  localparam int PERM_W     = 3;
  localparam int NUM_SHAPES = 4;
  localparam int NUM_SLOTS  = 5;
  localparam int SEL_W      = $clog2(NUM_SHAPES);
  localparam int SHAPE_W    = 3 * DIM_W + PERM_W;
  localparam int IDX_W      = 3 * DIM_W + 2;
  localparam int EN_LSB     = NUM_SLOTS * SEL_W;
  localparam int CTRL_W     = EN_LSB + NUM_SLOTS;

  typedef struct packed {
    logic                  step;
    logic                  restart;
    logic [NUM_SHAPES-1:0] shapeWe;
  } strobe_t;

  // Returns {outer, middle, inner} dimension numbers (0=x, 1=y, 2=z).
  function automatic logic [5:0] permOrder(input logic [PERM_W-1:0] code);
    case (code)
      3'd1:    permOrder = {2'd2, 2'd0, 2'd1};
      3'd2:    permOrder = {2'd1, 2'd2, 2'd0};
      3'd3:    permOrder = {2'd0, 2'd2, 2'd1};
      3'd4:    permOrder = {2'd1, 2'd0, 2'd2};
      3'd5:    permOrder = {2'd0, 2'd1, 2'd2};
      default: permOrder = {2'd2, 2'd1, 2'd0};
    endcase
  endfunction
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             shapeWe,
  input  logic [SEL_W-1:0]                 shapeSel,
  input  logic                             ctrlWe,
  input  logic [CTRL_W-1:0]                ctrlData,
  input  logic                             stepValid,
  input  logic [IDX_W-1:0]                 loopIdx,
  output strobe_t                          stb,
  output logic [NUM_SLOTS-1:0][SEL_W-1:0]  slotSel,
  output logic [NUM_SLOTS-1:0]             slotEn
);
  logic [CTRL_W-1:0] ctrlReg;

  always_ff @(posedge clk) begin
    if (!rstN)       ctrlReg <= '0;
    else if (ctrlWe) ctrlReg <= ctrlData;
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign slotSel[k] = ctrlReg[k*SEL_W +: SEL_W];
    assign slotEn[k]  = ctrlReg[EN_LSB + k];
  end

  for (genvar s = 0; s < NUM_SHAPES; s++) begin : g_we
    assign stb.shapeWe[s] = shapeWe && (shapeSel == SEL_W'(s));
  end

  assign stb.step    = stepValid;
  assign stb.restart = stepValid && (loopIdx == '0);
endmodule

// File: rtl/remap_shape_gen.sv
module remap_shape_gen
  import remap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               shapeWe,
  input  logic [SHAPE_W-1:0] shapeData,
  input  logic               step,
  input  logic               restart,
  output logic [IDX_W-1:0]   curIdx
);
  logic [SHAPE_W-1:0]          shapeReg;
  logic [2:0][DIM_W-1:0]       lim, cnt, base, nxt;
  logic [1:0]                  dIn, dMid, dOut;
  logic [IDX_W-1:0]            rowLen, planeLen;

  always_ff @(posedge clk) begin
    if (!rstN)        shapeReg <= '0;
    else if (shapeWe) shapeReg <= shapeData;
  end

  assign lim = shapeReg[3*DIM_W-1:0];
  assign {dOut, dMid, dIn} = permOrder(shapeReg[SHAPE_W-1 -: PERM_W]);
  assign base = restart ? '0 : cnt;

  always_comb begin
    nxt = base;
    if (base[dIn] == lim[dIn]) begin
      nxt[dIn] = '0;
      if (base[dMid] == lim[dMid]) begin
        nxt[dMid] = '0;
        nxt[dOut] = (base[dOut] == lim[dOut]) ? '0 : base[dOut] + 1'b1;
      end else begin
        nxt[dMid] = base[dMid] + 1'b1;
      end
    end else begin
      nxt[dIn] = base[dIn] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     cnt <= '0;
    else if (step) cnt <= nxt;
  end

  assign rowLen   = IDX_W'(lim[0]) + 1'b1;
  assign planeLen = rowLen * (IDX_W'(lim[1]) + 1'b1);
  assign curIdx   = IDX_W'(base[0]) + IDX_W'(base[1]) * rowLen
                  + IDX_W'(base[2]) * planeLen;
endmodule

// File: rtl/remap_datapath.sv
module remap_datapath
  import remap_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          stb,
  input  logic [SHAPE_W-1:0]               shapeData,
  input  logic [IDX_W-1:0]                 loopIdx,
  input  logic [NUM_SLOTS-1:0][SEL_W-1:0]  slotSel,
  input  logic [NUM_SLOTS-1:0]             slotEn,
  output logic                             outValid,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0]  slotIdx,
  output logic [NUM_SLOTS-1:0]             slotActive
);
  logic [NUM_SHAPES-1:0][IDX_W-1:0] genIdx;

  for (genvar s = 0; s < NUM_SHAPES; s++) begin : g_gen
    remap_shape_gen u_gen (
      .clk       (clk),
      .rstN      (rstN),
      .shapeWe   (stb.shapeWe[s]),
      .shapeData (shapeData),
      .step      (stb.step),
      .restart   (stb.restart),
      .curIdx    (genIdx[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= stb.step;
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotIdx[k]    <= '0;
        slotActive[k] <= 1'b0;
      end else if (stb.step) begin
        slotIdx[k]    <= slotEn[k] ? genIdx[slotSel[k]] : loopIdx;
        slotActive[k] <= slotEn[k];
      end
    end
  end
endmodule

// File: rtl/vec_remap.sv
module vec_remap
  import remap_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       shapeWe,
  input  logic [SEL_W-1:0]           shapeSel,
  input  logic [SHAPE_W-1:0]         shapeData,
  input  logic                       ctrlWe,
  input  logic [CTRL_W-1:0]          ctrlData,
  input  logic                       stepValid,
  input  logic [IDX_W-1:0]           loopIdx,
  output logic                       outValid,
  output logic [NUM_SLOTS*IDX_W-1:0] remapIdx,
  output logic [NUM_SLOTS-1:0]       remapActive
);
  strobe_t                            stb;
  logic [NUM_SLOTS-1:0][SEL_W-1:0]    slotSel;
  logic [NUM_SLOTS-1:0]               slotEn;
  logic [NUM_SLOTS-1:0][IDX_W-1:0]    slotIdx;

  remap_ctrl u_ctrl (
    .clk, .rstN, .shapeWe, .shapeSel, .ctrlWe, .ctrlData,
    .stepValid, .loopIdx, .stb, .slotSel, .slotEn
  );

  remap_datapath u_dp (
    .clk, .rstN, .stb, .shapeData, .loopIdx, .slotSel, .slotEn,
    .outValid, .slotIdx, .slotActive (remapActive)
  );

  assign remapIdx = slotIdx;
endmodule

// File: rtl/vec_remap_chk.sv
module vec_remap_chk
  import remap_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       stepValid,
  input logic [IDX_W-1:0]           loopIdx,
  input logic                       outValid,
  input logic [NUM_SLOTS*IDX_W-1:0] remapIdx,
  input logic [NUM_SLOTS-1:0]       remapActive
);
  p_valid_after_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |=> outValid);

  p_no_valid_when_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stepValid |=> !outValid);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stepValid |=> ($stable(remapIdx) && $stable(remapActive)));

  p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && loopIdx == '0) |=> (remapIdx == '0));

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_pass
    p_passthru_r3: assert property (@(posedge clk) disable iff (!rstN)
      stepValid |=> (remapActive[k] || remapIdx[k*IDX_W +: IDX_W] == $past(loopIdx)));
  end
endmodule

bind vec_remap vec_remap_chk u_chk (
  .clk, .rstN, .stepValid, .loopIdx, .outValid, .remapIdx, .remapActive
);

// File: tb/vec_remap_tb.sv
`timescale 1ns/1ps
module vec_remap_tb;
  import remap_pkg::*;

  logic                       clk = 1'b0;
  logic                       rstN = 1'b0;
  logic                       shapeWe = 1'b0;
  logic [SEL_W-1:0]           shapeSel = '0;
  logic [SHAPE_W-1:0]         shapeData = '0;
  logic                       ctrlWe = 1'b0;
  logic [CTRL_W-1:0]          ctrlData = '0;
  logic                       stepValid = 1'b0;
  logic [IDX_W-1:0]           loopIdx = '0;
  logic                       outValid;
  logic [NUM_SLOTS*IDX_W-1:0] remapIdx;
  logic [NUM_SLOTS-1:0]       remapActive;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  vec_remap u_dut (.*);

  // {tag, shape word, loop counter, expected slot A index}
  localparam int NV = 30;
  localparam logic [67:0] VEC [NV] = '{
    {4'd5, 32'h00040082, 16'd0, 16'd0}, {4'd5, 32'h00040082, 16'd1, 16'd3},
    {4'd5, 32'h00040082, 16'd2, 16'd6}, {4'd5, 32'h00040082, 16'd3, 16'd1},
    {4'd5, 32'h00040082, 16'd4, 16'd4}, {4'd5, 32'h00040082, 16'd5, 16'd7},
    {4'd5, 32'h00040082, 16'd6, 16'd2}, {4'd5, 32'h00040082, 16'd7, 16'd5},
    {4'd5, 32'h00040082, 16'd8, 16'd8}, {4'd7, 32'h00040082, 16'd9, 16'd0},
    {4'd6, 32'h00141041, 16'd0, 16'd0}, {4'd6, 32'h00141041, 16'd1, 16'd4},
    {4'd6, 32'h00141041, 16'd2, 16'd2}, {4'd6, 32'h00141041, 16'd3, 16'd6},
    {4'd6, 32'h00141041, 16'd4, 16'd1}, {4'd6, 32'h00141041, 16'd5, 16'd5},
    {4'd6, 32'h00141041, 16'd6, 16'd3}, {4'd6, 32'h00141041, 16'd7, 16'd7},
    {4'd4, 32'h00000042, 16'd0, 16'd0}, {4'd4, 32'h00000042, 16'd1, 16'd1},
    {4'd4, 32'h00000042, 16'd2, 16'd2}, {4'd4, 32'h00000042, 16'd3, 16'd3},
    {4'd4, 32'h00000042, 16'd4, 16'd4}, {4'd4, 32'h00000042, 16'd5, 16'd5},
    {4'd11, 32'h001C0081, 16'd0, 16'd0}, {4'd11, 32'h001C0081, 16'd1, 16'd1},
    {4'd11, 32'h001C0081, 16'd2, 16'd2}, {4'd11, 32'h001C0081, 16'd3, 16'd3},
    {4'd11, 32'h001C0081, 16'd4, 16'd4}, {4'd11, 32'h001C0081, 16'd5, 16'd5}
  };

  function automatic string tagName(input int t);
    case (t)
      4: tagName = "R4";
      5: tagName = "R5";
      6: tagName = "R6";
      7: tagName = "R7";
      default: tagName = "R11";
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] slot(input int k);
    slot = remapIdx[k*IDX_W +: IDX_W];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrShape(input int s, input logic [SHAPE_W-1:0] d);
    shapeWe = 1'b1; shapeSel = SEL_W'(s); shapeData = d;
    @(negedge clk);
    shapeWe = 1'b0;
  endtask

  task automatic wrCtrl(input logic [CTRL_W-1:0] d);
    ctrlWe = 1'b1; ctrlData = d;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic step(input int i);
    stepValid = 1'b1; loopIdx = IDX_W'(i);
    @(negedge clk);
    stepValid = 1'b0;
  endtask

  initial begin
    logic [31:0] lastShape;
    logic [IDX_W-1:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(outValid == 1'b0, "R1", outValid, 0);
    chk(remapIdx == '0, "R1", remapIdx[IDX_W-1:0], 0);
    chk(remapActive == '0, "R1", remapActive, 0);

    // R3: all enables clear, every slot passes the loop counter
    wrCtrl('0);
    step(37);
    for (int k = 0; k < NUM_SLOTS; k++)
      chk(slot(k) == 37, "R3", slot(k), 37);
    chk(remapActive == '0, "R3", remapActive, 0);
    // R2: valid follows the step, then drops
    chk(outValid == 1'b1, "R2", outValid, 1);
    @(negedge clk);
    chk(outValid == 1'b0, "R2", outValid, 0);

    // Table walk: slot A remapped through generator 0, slot B linear
    wrCtrl(15'h0400);
    lastShape = '1;
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][63:32] != lastShape) begin
        wrShape(0, VEC[v][SHAPE_W+31:32]);
        lastShape = VEC[v][63:32];
      end
      step(int'(VEC[v][31:16]));
      chk(slot(0) == IDX_W'(VEC[v][15:0]), tagName(int'(VEC[v][67:64])), slot(0), VEC[v][15:0]);
      chk(slot(1) == IDX_W'(VEC[v][31:16]), "R3", slot(1), VEC[v][31:16]);
      chk(remapActive == 5'b00001, "R9", remapActive, 1);
    end

    // R9: mixed mapping, slots A and C share generator 1
    wrShape(0, 21'h000042);
    wrShape(1, 21'h040082);
    wrShape(2, 21'h000082);
    wrShape(3, 21'h141041);
    wrCtrl(15'h7CD9);
    step(0);
    chk(remapIdx == '0, "R8", slot(0), 0);
    step(1);
    chk(slot(0) == 3, "R9", slot(0), 3);
    chk(slot(1) == 1, "R9", slot(1), 1);
    chk(slot(2) == slot(0), "R9", slot(2), slot(0));
    chk(slot(3) == 4, "R9", slot(3), 4);
    chk(slot(4) == 1, "R9", slot(4), 1);
    chk(remapActive == 5'b11111, "R9", remapActive, 31);
    // R10: idle cycles hold outputs and counters
    held = slot(3);
    repeat (3) @(negedge clk);
    chk(slot(3) == held && outValid == 1'b0, "R10", slot(3), held);
    step(2);
    chk(slot(0) == 6, "R10", slot(0), 6);
    chk(slot(3) == 2, "R10", slot(3), 2);
    // R8: restart mid-walk
    step(0);
    for (int k = 0; k < NUM_SLOTS; k++)
      chk(slot(k) == 0, "R8", slot(k), 0);
    step(1);
    chk(slot(0) == 3, "R8", slot(0), 3);
    chk(slot(3) == 4, "R8", slot(3), 4);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule